// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of one synthesizer channel. It is clocked by the output of an external dual-modulus prescaler. It drives a modulus line that tells that prescaler to divide by P+1 or by P. Over one output period the VCO sees exactly N cycles, where N = P·B + A. The programmed word `n_word` is split into a swallow count A (the low bits) and a main count B (the remaining high bits). The `pair_sel` input picks the smaller or the larger modulus pair, and that choice also sets how many low bits form A.

The main count runs for B prescaler cycles per period. The modulus line requests P+1 during the first A of those cycles and P during the rest. A single-cycle pulse marks the last cycle, and both counts then reload from the inputs together. Two parameters set the word width and the swallow width of the smaller pair. The defaults (18-bit word, 5-bit swallow, pairs 32/33 and 64/65) fit an RF channel. Width 15 with swallow 3 gives an IF channel with pairs 8/9 and 16/17. A powerdown input parks the divider in its reload state.

Top module: `dual_mod_divider`

## Requirements
- R1: With `pair_sel`=0, A = `n_word`[SW_LO-1:0], B = `n_word` >> SW_LO and P = 2^SW_LO. With `pair_sel`=1, A = `n_word`[SW_LO:0], B = `n_word` >> (SW_LO+1) and P = 2^(SW_LO+1). With the defaults this gives P = 32 or 64, and each period spans P·B + A VCO cycles.
- R2: `mod_hi`=1 requests P+1 from the prescaler. Within each period it is high for exactly the first A prescaler cycles and low for the remaining ones.
- R3: `div_pulse` is high for exactly one clock, on the last (B-th) prescaler cycle of a period. The next cycle starts a new period.
- R4: When B < A, the effective main count is A. When both are zero, it is 1.
- R5: `n_word` and `pair_sel` are sampled only at the clock edge that starts a period. Changes during a period take effect only in the following period.
- R6: While `pwdn` is sampled high, both outputs are low from the next edge on. The first edge that samples `pwdn` low starts a period (cycle 0) from the inputs at that edge.
- R7: `rst` is synchronous and active high, and it clears both outputs. The first edge after release starts a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| n_word | input | N_W | Total division value N |
| pair_sel | input | 1 | 0: smaller modulus pair, 1: larger pair |
| pwdn | input | 1 | Powerdown; holds the divider in reload |
| mod_hi | output | 1 | Registered; 1 requests P+1 from the prescaler |
| div_pulse | output | 1 | Registered one-cycle pulse per period |

## Verification
A wrong swallow count shows at the ports within one period, as a wrong number of high cycles on `mod_hi`. It also shows as a VCO total that differs from P·B + A by a multiple of one. A wrong main count or a missed reload moves `div_pulse` by whole prescaler cycles. The bench sees this at the first pulse after the fault, or flags a missing pulse once the expected B cycles pass. A bad field split or a broken sampling rule makes the VCO total for that period wrong by multiples of P. A powerdown or reset fault shows one edge after the control is asserted or released.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {
    PAIR_SMALL = 1'b0,
    PAIR_LARGE = 1'b1
  } pair_e;
endpackage

// File: rtl/psd_split.sv
module psd_split
  import psd_pkg::*;
#(
  parameter int N_W   = 18,
  parameter int SW_LO = 5
) (
  input  logic [N_W-1:0] n_word,
  input  logic           pair_sel,
  output logic [N_W-1:0] a_val,
  output logic [N_W-1:0] b_val
);
  localparam int SW_HI = SW_LO + 1;
  localparam logic [N_W-1:0] MASK_LO = {{(N_W-SW_LO){1'b0}}, {SW_LO{1'b1}}};
  localparam logic [N_W-1:0] MASK_HI = {{(N_W-SW_HI){1'b0}}, {SW_HI{1'b1}}};

  logic [N_W-1:0] a_raw, b_raw, b_floor;

  always_comb begin
    if (pair_e'(pair_sel) == PAIR_LARGE) begin
      a_raw = n_word & MASK_HI;
      b_raw = n_word >> SW_HI;
    end else begin
      a_raw = n_word & MASK_LO;
      b_raw = n_word >> SW_LO;
    end
    // main count may not be shorter than the swallow count, nor zero
    b_floor = (b_raw < a_raw) ? a_raw : b_raw;
    b_val   = (b_floor == '0) ? N_W'(1) : b_floor;
    a_val   = a_raw;
  end
endmodule

// File: rtl/psd_down_ctr.sv
module psd_down_ctr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nx
);
  always_comb begin
    if (clr)                cnt_nx = '0;
    else if (load)          cnt_nx = load_val;
    else if (cnt_q != '0)   cnt_nx = cnt_q - W'(1);
    else                    cnt_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider #(
  parameter int N_W   = 18,
  parameter int SW_LO = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] n_word,
  input  logic           pair_sel,
  input  logic           pwdn,
  output logic           mod_hi,
  output logic           div_pulse
);
  logic [N_W-1:0] a_val, b_val;
  logic [N_W-1:0] a_cnt, a_nx, b_cnt, b_nx;
  logic           run_q, reload;

  psd_split #(.N_W(N_W), .SW_LO(SW_LO)) u_split (
    .n_word(n_word), .pair_sel(pair_sel), .a_val(a_val), .b_val(b_val)
  );

  // a new period starts after idle or on the terminal main count
  assign reload = !run_q || (b_cnt == N_W'(1));

  psd_down_ctr #(.W(N_W)) u_swallow (
    .clk(clk), .rst(rst), .clr(pwdn), .load(reload), .load_val(a_val),
    .cnt_q(a_cnt), .cnt_nx(a_nx)
  );

  psd_down_ctr #(.W(N_W)) u_main (
    .clk(clk), .rst(rst), .clr(pwdn), .load(reload), .load_val(b_val),
    .cnt_q(b_cnt), .cnt_nx(b_nx)
  );

  always_ff @(posedge clk) begin
    if (rst || pwdn) begin
      run_q     <= 1'b0;
      mod_hi    <= 1'b0;
      div_pulse <= 1'b0;
    end else begin
      run_q     <= 1'b1;
      mod_hi    <= (a_nx != '0);
      div_pulse <= (b_nx == N_W'(1));
    end
  end
endmodule

// File: rtl/dual_mod_divider_chk.sv
module dual_mod_divider_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         pwdn,
  input logic         mod_hi,
  input logic         div_pulse,
  input logic         run_q,
  input logic [W-1:0] a_cnt,
  input logic [W-1:0] b_cnt
);
  logic rst_d;

  // R6: powerdown silences both outputs at the next edge
  p_quiet_pd_r6: assert property (@(posedge clk) disable iff (rst)
    pwdn |=> (!mod_hi && !div_pulse));

  // R2: within a running period the modulus request never returns after dropping
  p_mod_front_r2: assert property (@(posedge clk) disable iff (rst)
    (run_q && !pwdn && !mod_hi && !div_pulse) |=> !mod_hi);

  // R4: the swallow count never exceeds the main count, which never reaches zero
  p_swallow_fits_r4: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (a_cnt <= b_cnt && b_cnt != '0));

  // R7: outputs are low at the first edge after reset release
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (!rst && rst_d)
      a_reset_quiet_r7: assert (!mod_hi && !div_pulse);
  end
endmodule

bind dual_mod_divider dual_mod_divider_chk #(.W(N_W)) u_chk (
  .clk(clk), .rst(rst), .pwdn(pwdn), .mod_hi(mod_hi), .div_pulse(div_pulse),
  .run_q(run_q), .a_cnt(a_cnt), .b_cnt(b_cnt)
);

// File: tb/dual_mod_divider_tb.sv
`timescale 1ns/1ps
module dual_mod_divider_tb;
  localparam int NW  = 18;
  localparam int SWL = 5;
  localparam int PLO = 1 << SWL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0] n_word = '0;
  logic pair_sel = 1'b0;
  logic pwdn = 1'b0;
  logic mod_hi, div_pulse;

  int total = 0, bad = 0;
  bit start = 1'b1;
  int ea, eb, en, kc, acc, mc;
  bit eclamp, seen_low, chg;
  logic [NW-1:0] pa_n;
  logic pa_ps;

  always #4 clk = ~clk;

  dual_mod_divider #(.N_W(NW), .SW_LO(SWL)) u_dut (
    .clk(clk), .rst(rst), .n_word(n_word), .pair_sel(pair_sel),
    .pwdn(pwdn), .mod_hi(mod_hi), .div_pulse(div_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void calc(input logic [NW-1:0] n, input logic ps,
                               output int a, output int b, output int nexp, output bit cl);
    int p, bits, braw;
    p    = ps ? 2 * PLO : PLO;
    bits = ps ? SWL + 1 : SWL;
    a    = int'(n) & ((1 << bits) - 1);
    braw = int'(n) >> bits;
    b    = braw;
    if (b < a) b = a;
    if (b < 1) b = 1;
    cl   = (b != braw);
    nexp = p * b + a;
  endfunction

  function automatic logic [NW-1:0] mk(input int b, input int a, input bit ps);
    return NW'((b << (ps ? SWL + 1 : SWL)) | a);
  endfunction

  // sample at the falling edge: outputs reflect the inputs held at the last rising edge
  task automatic tick();
    @(negedge clk);
    if (rst) begin
      chk(!mod_hi && !div_pulse, "R7 reset outputs", {mod_hi, div_pulse}, 0);
      start = 1'b1;
      return;
    end
    if (pwdn) begin
      chk(!mod_hi && !div_pulse, "R6 powerdown outputs", {mod_hi, div_pulse}, 0);
      start = 1'b1;
      return;
    end
    if (start) begin
      calc(n_word, pair_sel, ea, eb, en, eclamp);
      pa_n = n_word; pa_ps = pair_sel;
      kc = 0; acc = 0; mc = 0; seen_low = 1'b0; chg = 1'b0;
    end
    start = 1'b0;
    kc++;
    acc += mod_hi ? (pa_ps ? 2 * PLO : PLO) + 1 : (pa_ps ? 2 * PLO : PLO);
    if (mod_hi) begin
      if (seen_low) chk(1'b0, "R2 modulus high after low", kc, ea);
      mc++;
    end else seen_low = 1'b1;
    if (n_word != pa_n || pair_sel != pa_ps) chg = 1'b1;
    if (div_pulse) begin
      chk(kc == eb, "R3 pulse position", kc, eb);
      chk(mc == ea, "R2 swallow cycles", mc, ea);
      if (eclamp)   chk(acc == en, "R4 clamped VCO total", acc, en);
      else if (chg) chk(acc == en, "R5 VCO total with mid-period change", acc, en);
      else          chk(acc == en, "R1 VCO total", acc, en);
      start = 1'b1;
    end else if (kc >= eb) begin
      chk(1'b0, "R3 missing pulse", kc, eb);
      start = 1'b1;
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5a17);
    n_word = mk(5, 3, 1'b0);
    repeat (4) tick();
    rst = 1'b0;
    repeat (25) tick();
    // R4 directed: B below A, and an all-zero word
    n_word = mk(3, 20, 1'b0);
    repeat (65) tick();
    n_word = '0;
    repeat (6) tick();
    // large pair at its swallow limit, then the shortest legal period
    pair_sel = 1'b1; n_word = mk(63, 63, 1'b1);
    repeat (130) tick();
    n_word = mk(1, 0, 1'b1);
    repeat (6) tick();
    // R6 directed: powerdown mid-period
    pair_sel = 1'b0; n_word = mk(9, 4, 1'b0);
    repeat (5) tick();
    pwdn = 1'b1;
    repeat (4) tick();
    pwdn = 1'b0;
    repeat (30) tick();
    // random phase
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 16 == 0) begin
        bit ps; int a, b;
        ps = 1'($urandom % 2);
        a  = int'($urandom % (ps ? 2 * PLO : PLO));
        b  = ($urandom % 4 == 0) ? int'($urandom % (a + 1)) : a + int'($urandom % 6);
        pair_sel = ps;
        n_word   = mk(b, a, ps);
      end
      if ($urandom % 200 == 0) pwdn = ~pwdn;
      else if (pwdn && $urandom % 4 == 0) pwdn = 1'b0;
      if ($urandom % 2000 == 0) rst = 1'b1;
      else rst = 1'b0;
      tick();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule